// File: doc/BRIEF.md
# PHY Register Access Sequencer

This block lets on-chip logic read and write the 16-bit configuration registers inside a serial-link PHY. The PHY has no address bus of its own. Everything passes through one outgoing control word and one incoming status word, and every transfer step is a four-phase request/acknowledge exchange. The block turns a single command (address, write data, direction, start pulse) into the full chain of exchanges. When the chain ends it returns the read data, a one-cycle done pulse and an error flag.

An access always starts by loading the register address into the PHY. A write then loads the data value and fires a write strobe. A read fires a read strobe and captures the value the PHY returns. Each acknowledge wait is polled on a slow tick of about one microsecond, made by an internal clock divider. When the acknowledge does not reach the expected level within a fixed number of polls, the access is abandoned and reported as an error.

Top module: `phy_reg_seq`

## Requirements
- R1: After reset the control word is zero, done and error are low, and the read data output is zero.
- R2: Control word layout: bits 15:0 carry an address or data value, bit 16 is capture-address, bit 17 is capture-data, bit 18 is the write strobe and bit 19 is the read strobe. At most one of bits 19:16 is high at any time. Status word layout: bits 15:0 are read data and bit 16 is the acknowledge.
- R3: Every access begins with this sequence: the address alone, then the address with capture-address, a wait for acknowledge high, the address alone again, and a wait for acknowledge low.
- R4: A write continues with: the data alone, then the data with capture-data, a wait for acknowledge high, the data alone, a wait for low, the write strobe alone, a wait for high, the data alone, and a wait for low. The control word then returns to zero and done pulses with error low.
- R5: A read continues with: the read strobe alone and a wait for acknowledge high. The status data is captured, the control word returns to zero, and after a wait for low, done pulses with the captured value on the read data output.
- R6: The read data output holds its value from done until the next accepted start.
- R7: Each wait polls the acknowledge once per tick, where a tick is TICK_DIV clocks, for at most MAX_POLLS (10) polls. An acknowledge seen on any of these polls, including the last one, lets the access continue.
- R8: If the acknowledge never rises, the access ends with done and error high together and the control word at zero. This happens between 9 and 10 tick periods after the start, and the block returns to idle.
- R9: If the acknowledge rises but never falls, the access also ends with a timeout error.
- R10: A start pulse that arrives while an access is in progress is ignored: no extra access and no extra done.
- R11: Done is high for exactly one cycle per access, and error is high only together with done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle request to begin an access |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | DATA_W | PHY register address |
| cmd_wdata | input | DATA_W | Value to write |
| rsp_rdata | output | DATA_W | Value returned by the last read |
| rsp_done | output | 1 | One-cycle pulse when an access ends |
| rsp_err | output | 1 | High with done when a wait timed out |
| ctl_word | output | DATA_W+4 | Control word to the PHY |
| stat_word | input | DATA_W+1 | Status word from the PHY |

## Verification
Two events can land on the same tick: the acknowledge reaching its expected level, and the poll counter reaching its limit. The design gives the acknowledge precedence. The bench's PHY model answers with a programmable latency. A latency just under nine tick periods must let every wait of a full write complete without error. A latency just over ten tick periods must end in a timeout, and the bench checks the error flag, the zeroed control word and the elapsed cycles.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  // Sequencer states; *_WH waits for ack high, *_WL waits for ack low.
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACAP,
    ST_AWH,
    ST_AWL,
    ST_DCAP,
    ST_DWH,
    ST_DWL,
    ST_WWH,
    ST_WWL,
    ST_RWH,
    ST_RWL
  } seq_state_e;
endpackage

// File: rtl/phy_tick_gen.sv
module phy_tick_gen #(
  parameter int DIV = 200
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/phy_ack_timer.sv
module phy_ack_timer #(
  parameter int MAX_POLLS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic armed,
  input  logic expect_hi,
  input  logic ack,
  output logic hit,
  output logic expired
);
  localparam int PW = $clog2(MAX_POLLS + 1);

  logic [PW-1:0] polls;
  logic          match;

  assign match = (ack == expect_hi);

  // A match wins over expiry on the final poll.
  always_comb begin
    hit     = armed && tick && match;
    expired = armed && tick && !match && (polls == PW'(MAX_POLLS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || !armed || hit || expired) begin
      polls <= '0;
    end else if (tick) begin
      polls <= polls + 1'b1;
    end
  end
endmodule

// File: rtl/phy_seq_fsm.sv
module phy_seq_fsm
  import phy_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_start,
  input  logic                cmd_write,
  input  logic [DATA_W-1:0]   cmd_addr,
  input  logic [DATA_W-1:0]   cmd_wdata,
  input  logic [DATA_W-1:0]   stat_data,
  input  logic                ack_hit,
  input  logic                ack_expired,
  output logic                wait_armed,
  output logic                wait_hi,
  output logic [DATA_W+3:0]   ctl_word,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_done,
  output logic                rsp_err
);
  localparam int CTL_W  = DATA_W + 4;
  localparam int BIT_CA = DATA_W;
  localparam int BIT_CD = DATA_W + 1;
  localparam int BIT_WR = DATA_W + 2;
  localparam int BIT_RD = DATA_W + 3;
  localparam logic [CTL_W-1:0] CA_MASK = CTL_W'(1) << BIT_CA;
  localparam logic [CTL_W-1:0] CD_MASK = CTL_W'(1) << BIT_CD;
  localparam logic [CTL_W-1:0] WR_MASK = CTL_W'(1) << BIT_WR;
  localparam logic [CTL_W-1:0] RD_MASK = CTL_W'(1) << BIT_RD;

  seq_state_e        state;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_q;

  function automatic logic [CTL_W-1:0] value_only(input logic [DATA_W-1:0] v);
    return {4'b0000, v};
  endfunction

  always_comb begin
    wait_armed = (state == ST_AWH) || (state == ST_AWL) || (state == ST_DWH) ||
                 (state == ST_DWL) || (state == ST_WWH) || (state == ST_WWL) ||
                 (state == ST_RWH) || (state == ST_RWL);
    wait_hi    = (state == ST_AWH) || (state == ST_DWH) ||
                 (state == ST_WWH) || (state == ST_RWH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ctl_word  <= '0;
      rsp_rdata <= '0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      wr_q      <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      if (ack_expired) begin
        ctl_word <= '0;
        rsp_done <= 1'b1;
        rsp_err  <= 1'b1;
        state    <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: if (cmd_start) begin
            addr_q   <= cmd_addr;
            data_q   <= cmd_wdata;
            wr_q     <= cmd_write;
            ctl_word <= value_only(cmd_addr);
            state    <= ST_ACAP;
          end
          ST_ACAP: begin
            ctl_word <= value_only(addr_q) | CA_MASK;
            state    <= ST_AWH;
          end
          ST_AWH: if (ack_hit) begin
            ctl_word <= value_only(addr_q);
            state    <= ST_AWL;
          end
          ST_AWL: if (ack_hit) begin
            if (wr_q) begin
              ctl_word <= value_only(data_q);
              state    <= ST_DCAP;
            end else begin
              ctl_word <= RD_MASK;
              state    <= ST_RWH;
            end
          end
          ST_DCAP: begin
            ctl_word <= value_only(data_q) | CD_MASK;
            state    <= ST_DWH;
          end
          ST_DWH: if (ack_hit) begin
            ctl_word <= value_only(data_q);
            state    <= ST_DWL;
          end
          ST_DWL: if (ack_hit) begin
            ctl_word <= WR_MASK;
            state    <= ST_WWH;
          end
          ST_WWH: if (ack_hit) begin
            ctl_word <= value_only(data_q);
            state    <= ST_WWL;
          end
          ST_WWL: if (ack_hit) begin
            ctl_word <= '0;
            rsp_done <= 1'b1;
            state    <= ST_IDLE;
          end
          ST_RWH: if (ack_hit) begin
            rsp_rdata <= stat_data;
            ctl_word  <= '0;
            state     <= ST_RWL;
          end
          ST_RWL: if (ack_hit) begin
            rsp_done <= 1'b1;
            state    <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/phy_reg_seq.sv
module phy_reg_seq #(
  parameter int DATA_W    = 16,
  parameter int TICK_DIV  = 200,
  parameter int MAX_POLLS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W+3:0] ctl_word,
  input  logic [DATA_W:0]   stat_word
);
  localparam int ACK_BIT = DATA_W;

  logic tick;
  logic armed;
  logic expect_hi;
  logic hit;
  logic expired;

  phy_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  phy_ack_timer #(.MAX_POLLS(MAX_POLLS)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .armed     (armed),
    .expect_hi (expect_hi),
    .ack       (stat_word[ACK_BIT]),
    .hit       (hit),
    .expired   (expired)
  );

  phy_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .cmd_start   (cmd_start),
    .cmd_write   (cmd_write),
    .cmd_addr    (cmd_addr),
    .cmd_wdata   (cmd_wdata),
    .stat_data   (stat_word[DATA_W-1:0]),
    .ack_hit     (hit),
    .ack_expired (expired),
    .wait_armed  (armed),
    .wait_hi     (expect_hi),
    .ctl_word    (ctl_word),
    .rsp_rdata   (rsp_rdata),
    .rsp_done    (rsp_done),
    .rsp_err     (rsp_err)
  );
endmodule

// File: rtl/phy_reg_seq_chk.sv
module phy_reg_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_start,
  input logic              rsp_done,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [DATA_W+3:0] ctl_word
);
  logic held;

  always_ff @(posedge clk) begin
    if (rst)            held <= 1'b0;
    else if (cmd_start) held <= 1'b0;
    else if (rsp_done)  held <= 1'b1;
  end

  // R11: done lasts one cycle
  p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R11: error only together with done
  p_err_needs_done_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_done);

  // R2: at most one request bit high
  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctl_word[DATA_W+3:DATA_W]));

  // R4: control word is zero whenever an access ends
  p_ctl_zero_at_done_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> (ctl_word == '0));

  // R6: read data held between done and the next start
  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (held && !cmd_start) |=> $stable(rsp_rdata));
endmodule

bind phy_reg_seq phy_reg_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_start (cmd_start),
  .rsp_done  (rsp_done),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .ctl_word  (ctl_word)
);

// File: tb/phy_reg_seq_tb.sv
`timescale 1ns/1ps
module phy_reg_seq_tb;
  localparam int DIV = 20;
  localparam logic [19:0] CA = 20'h10000;
  localparam logic [19:0] CD = 20'h20000;
  localparam logic [19:0] WR = 20'h40000;
  localparam logic [19:0] RD = 20'h80000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 1'b0;
  logic        cmd_write = 1'b0;
  logic [15:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic [15:0] rsp_rdata;
  logic        rsp_done;
  logic        rsp_err;
  logic [19:0] ctl_word;
  logic [16:0] stat_word;

  int n_chk = 0;
  int n_fail = 0;
  int done_cnt = 0;

  always #2.5 clk = ~clk;

  phy_reg_seq #(.DATA_W(16), .TICK_DIV(DIV), .MAX_POLLS(10)) u_dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .ctl_word(ctl_word),
    .stat_word(stat_word)
  );

  // PHY model: mode 0 normal, 1 ack never rises, 2 ack never falls
  int          phy_mode = 0;
  int          phy_lat = 3;
  logic        m_ack;
  int          m_cnt;
  logic [15:0] m_addr, m_data, m_out;
  logic [15:0] m_mem [16];
  logic [19:0] m_prev;
  logic        m_tgt;

  assign stat_word = {m_ack, m_out};

  always @(posedge clk) begin
    if (rst) begin
      m_ack <= 1'b0; m_cnt <= 0; m_addr <= '0; m_data <= '0; m_out <= '0;
      m_prev <= '0;
      for (int i = 0; i < 16; i++) m_mem[i] <= '0;
    end else begin
      m_prev <= ctl_word;
      m_tgt = |ctl_word[19:16];
      if (phy_mode == 1) m_tgt = 1'b0;
      if (phy_mode == 2 && m_ack) m_tgt = 1'b1;
      if (m_tgt != m_ack) begin
        if (m_cnt >= phy_lat) begin m_ack <= m_tgt; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end else m_cnt <= 0;
      if (ctl_word[16] && !m_prev[16]) m_addr <= ctl_word[15:0];
      if (ctl_word[17] && !m_prev[17]) m_data <= ctl_word[15:0];
      if (ctl_word[18] && !m_prev[18]) m_mem[m_addr[3:0]] <= m_data;
      if (ctl_word[19] && !m_prev[19]) m_out <= m_mem[m_addr[3:0]];
    end
  end

  // Control word trace
  logic [19:0] logv [32];
  int          log_n = 0;
  logic [19:0] prev_ctl = '0;
  always begin
    @(posedge clk); #1;
    if (rsp_done) done_cnt++;
    if (ctl_word !== prev_ctl) begin
      if (log_n < 32) logv[log_n] = ctl_word;
      log_n++;
      prev_ctl = ctl_word;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_entry(input int i, input logic [19:0] v, input string req);
    check(log_n > i && logv[i] == v, req, $sformatf("trace[%0d]", i),
          (log_n > i) ? {12'h0, logv[i]} : 32'hFFFFFFFF, {12'h0, v});
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                            input int poke, output logic [15:0] rd,
                            output bit er, output int cyc);
    @(negedge clk);
    log_n = 0;
    cmd_write = wr; cmd_addr = a; cmd_wdata = d; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    cyc = 1;
    while (!rsp_done && cyc < 5000) begin
      cmd_start = (cyc == poke);
      if (cyc == poke) begin cmd_addr = ~a; cmd_write = 1'b1; cmd_wdata = 16'hDEAD; end
      @(negedge clk);
      cyc++;
    end
    cmd_start = 1'b0;
    check(rsp_done, "R11", "done seen", {31'h0, rsp_done}, 32'h1);
    rd = rsp_rdata;
    er = rsp_err;
    check(ctl_word == 20'h0, "R4", "ctl zero at done", {12'h0, ctl_word}, 32'h0);
    @(negedge clk);
    check(!rsp_done && !rsp_err, "R11", "done/err one cycle",
          {30'h0, rsp_done, rsp_err}, 32'h0);
  endtask

  task automatic chk_write_trace(input logic [15:0] a, input logic [15:0] d, input string req);
    chk_entry(0, {4'h0, a}, "R3");
    chk_entry(1, {4'h0, a} | CA, "R3");
    chk_entry(2, {4'h0, a}, "R3");
    chk_entry(3, {4'h0, d}, req);
    chk_entry(4, {4'h0, d} | CD, req);
    chk_entry(5, {4'h0, d}, req);
    chk_entry(6, WR, req);
    chk_entry(7, {4'h0, d}, req);
    chk_entry(8, 20'h0, req);
    check(log_n == 9, req, "trace length", log_n, 9);
  endtask

  task automatic test_reset();
    check(ctl_word == 20'h0, "R1", "ctl after reset", {12'h0, ctl_word}, 0);
    check(!rsp_done, "R1", "done after reset", {31'h0, rsp_done}, 0);
    check(!rsp_err, "R1", "err after reset", {31'h0, rsp_err}, 0);
    check(rsp_rdata == 16'h0, "R1", "rdata after reset", {16'h0, rsp_rdata}, 0);
  endtask

  task automatic test_write_read(input logic [15:0] a, input logic [15:0] d);
    logic [15:0] rd; bit er; int cyc;
    run_access(1'b1, a, d, -1, rd, er, cyc);
    check(!er, "R4", "write err", {31'h0, er}, 0);
    chk_write_trace(a, d, "R4");
    settle(30);
    run_access(1'b0, a, 16'h0, -1, rd, er, cyc);
    check(!er, "R5", "read err", {31'h0, er}, 0);
    check(rd == d, "R5", "read value", {16'h0, rd}, {16'h0, d});
    chk_entry(0, {4'h0, a}, "R3");
    chk_entry(1, {4'h0, a} | CA, "R3");
    chk_entry(2, {4'h0, a}, "R3");
    chk_entry(3, RD, "R5");
    chk_entry(4, 20'h0, "R5");
    check(log_n == 5, "R5", "read trace length", log_n, 5);
    settle(100);
    check(rsp_rdata == d, "R6", "rdata held", {16'h0, rsp_rdata}, {16'h0, d});
  endtask

  task automatic test_slow_ack_ok();
    logic [15:0] rd; bit er; int cyc;
    phy_lat = 9 * DIV - 5;
    run_access(1'b1, 16'h1234, 16'h8000, -1, rd, er, cyc);
    check(!er, "R7", "slow ack within limit", {31'h0, er}, 0);
    chk_write_trace(16'h1234, 16'h8000, "R7");
    phy_lat = 3;
    settle(300);
    run_access(1'b0, 16'h1234, 16'h0, -1, rd, er, cyc);
    check(rd == 16'h8000 && !er, "R7", "slow write stored", {16'h0, rd}, 32'h8000);
  endtask

  task automatic test_timeout_rise();
    logic [15:0] rd; bit er; int cyc;
    phy_mode = 1;
    run_access(1'b1, 16'h0007, 16'h5555, -1, rd, er, cyc);
    check(er, "R8", "timeout err", {31'h0, er}, 1);
    check(cyc >= 9 * DIV && cyc <= 10 * DIV + 8, "R8", "timeout cycles", cyc, 10 * DIV);
    phy_mode = 0;
    settle(300);
  endtask

  task automatic test_slow_ack_fail();
    logic [15:0] rd; bit er; int cyc;
    phy_lat = 10 * DIV + 15;
    run_access(1'b0, 16'h0002, 16'h0, -1, rd, er, cyc);
    check(er, "R7", "ack beyond limit times out", {31'h0, er}, 1);
    phy_lat = 3;
    settle(400);
  endtask

  task automatic test_timeout_fall();
    logic [15:0] rd; bit er; int cyc;
    phy_mode = 2;
    run_access(1'b1, 16'h0009, 16'h3333, -1, rd, er, cyc);
    check(er, "R9", "stuck-high err", {31'h0, er}, 1);
    chk_entry(2, 20'h00009, "R9");
    phy_mode = 0;
    settle(300);
  endtask

  task automatic test_busy_start();
    logic [15:0] rd; bit er; int cyc; int d0;
    d0 = done_cnt;
    run_access(1'b1, 16'h0003, 16'h1111, 10, rd, er, cyc);
    check(!er, "R10", "write with busy start", {31'h0, er}, 0);
    chk_write_trace(16'h0003, 16'h1111, "R10");
    settle(600);
    check(done_cnt - d0 == 1, "R10", "single done", done_cnt - d0, 1);
    check(ctl_word == 20'h0, "R10", "ctl idle after", {12'h0, ctl_word}, 0);
    run_access(1'b0, 16'hFFFC, 16'h0, -1, rd, er, cyc);
    check(rd == 16'h0000, "R10", "ignored write not stored", {16'h0, rd}, 0);
    run_access(1'b0, 16'h0003, 16'h0, -1, rd, er, cyc);
    check(rd == 16'h1111, "R10", "real write stored", {16'h0, rd}, 32'h1111);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_write_read(16'h0005, 16'hA5C3);
    test_write_read(16'hFFFF, 16'h0001);
    test_slow_ack_ok();
    test_timeout_rise();
    test_slow_ack_fail();
    test_timeout_fall();
    test_busy_start();
    finish_run();
  end
endmodule